// File: doc/BRIEF.md
# Split-Screen Display Address Generator

This block walks the frame buffer while a panel is scanned and gives the word address of each fetch. A frame begins with a frame-start strobe. Each line begins with a line-start strobe, and each pixel-group fetch is a word request. The upper lines show an image based at a first start word address. After a programmable split line, the remaining lines show an image based at a second start word address. From one line to the next the base advances by the visible line width in words plus a pitch adjustment. This lets the stored image be wider than the panel.

Configuration is sampled only at frame start, so software may rewrite it at any time without tearing the frame being shown. Memory arbitration, pixel serialisation and panel timing are outside this block.

The state machine has five states:
- `ST_IDLE`: after reset.
- `ST_ARMED`: frame started, no line yet.
- `ST_FETCH`: line in progress, words still to fetch.
- `ST_HOLD`: every word of the line has been fetched.
- `ST_DONE`: the last panel line has ended.

It has these transitions:
- `frame_start` from any state to `ST_ARMED`.
- `line_start`:
  - from `ST_ARMED` to `ST_FETCH` (first line).
  - from `ST_FETCH` or `ST_HOLD` to `ST_FETCH` (next line).
  - from `ST_FETCH` or `ST_HOLD` on the last line to `ST_DONE` (frame over).
- `word_req` on the final word from `ST_FETCH` to `ST_HOLD` (line filled).

Top module: `split_scan_addr_gen`

## Requirements
- R1: After reset `fetch_valid`, `frame_done` and `screen2` are low, and `fetch_addr` and `line_num` are zero.
- R2: Configuration is sampled on `frame_start`. Changes at other times have no effect on the current frame. `frame_start` in any state restarts the frame in the armed state and wins over a `line_start` in the same cycle.
- R3: The first `line_start` after `frame_start` begins line 0. On that line `fetch_addr` equals the screen-1 base, `screen2` is low and `fetch_valid` is high.
- R4: Words per line are ceil(8·(hsize+1)·2^bpp_code / 16). The `bpp_code` values 0, 1, 2 and 3 select 1, 2, 4 and 8 bits per pixel.
- R5: Each accepted `word_req` in a line raises `fetch_addr` by one, modulo 2^ADDR_W. After the line's word count of requests `fetch_valid` falls and further `word_req` pulses leave `fetch_addr` unchanged.
- R6: When a line index is below the last line and differs from the split value, the next line's base is the previous base plus words per line plus the pitch adjustment, modulo 2^ADDR_W.
- R7: The line after the line whose index equals the split value starts at the screen-2 base. Every line with index above the split value has `screen2` high and advances by the same stride. For split 0xCE on a 240-line panel, 207 lines are screen 1 and 33 are screen 2.
- R8: A `line_start` during the line whose index equals the last-line value ends the frame. `frame_done` goes high, `fetch_valid` goes low, and `line_start` and `word_req` are ignored until the next `frame_start`.
- R9: When the split value is equal to or larger than the last-line value, `screen2` stays low for the whole frame.
- R10: A `line_start` in the same cycle as a `word_req` begins the new line at its base with the word request dropped. A `line_start` during an unfinished line abandons the rest of that line.
- R11: `word_req` is ignored outside a line in progress, and `line_start` is ignored before the first `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle frame begin strobe |
| line_start | input | 1 | One-cycle line begin strobe |
| word_req | input | 1 | One-cycle word fetch request |
| cfg_s1_base | input | ADDR_W | Screen-1 start word address |
| cfg_s2_base | input | ADDR_W | Screen-2 start word address |
| cfg_split | input | LINE_W | Index of the last screen-1 line |
| cfg_last_line | input | LINE_W | Panel height minus one |
| cfg_hsize | input | HREG_W | Panel width code, width = 8·(hsize+1) pixels |
| cfg_bpp_code | input | 2 | Pixel depth code |
| cfg_pitch | input | PITCH_W | Extra words between lines |
| fetch_addr | output | ADDR_W | Current fetch word address |
| fetch_valid | output | 1 | A line is in progress with words remaining |
| screen2 | output | 1 | Current line is taken from screen 2 |
| line_num | output | LINE_W | Current line index |
| frame_done | output | 1 | Last line of the frame has ended |

## Verification
The bench builds the block with LINE_W set to 8 and the other parameters at their defaults. An eight-bit line index holds the full 240-line panel with the 0xCE split. With 16-bit addresses, a base near the top of the address space makes the modulo wrap of both the in-line increment and the line stride reachable in a few words. The full 11-bit word counter covers all four pixel depths, including the rounded-up single-word line at the narrowest width.

// File: rtl/split_addr_pkg.sv
package split_addr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_FETCH = 3'd2,
        ST_HOLD  = 3'd3,
        ST_DONE  = 3'd4
    } scan_state_t;

    localparam int BPP_CODES = 4;

endpackage

// File: rtl/split_cfg_shadow.sv
module split_cfg_shadow
    import split_addr_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int LINE_W  = 10,
    parameter int HREG_W  = 8,
    parameter int PITCH_W = 8,
    localparam int WPL_W  = HREG_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [ADDR_W-1:0] cfg_s1_base,
    input  logic [ADDR_W-1:0] cfg_s2_base,
    input  logic [LINE_W-1:0] cfg_split,
    input  logic [LINE_W-1:0] cfg_last_line,
    input  logic [HREG_W-1:0] cfg_hsize,
    input  logic [1:0]        cfg_bpp_code,
    input  logic [PITCH_W-1:0] cfg_pitch,
    output logic [ADDR_W-1:0] s1_q,
    output logic [ADDR_W-1:0] s2_q,
    output logic [LINE_W-1:0] split_q,
    output logic [LINE_W-1:0] last_q,
    output logic [WPL_W-1:0]  wpl_q,
    output logic [ADDR_W-1:0] stride_q
);

    localparam int BITS_W = HREG_W + 7;

    logic [BITS_W-1:0] pix_groups;
    logic [WPL_W-1:0]  wpl_cand [BPP_CODES];
    logic [WPL_W-1:0]  wpl_new;

    assign pix_groups = BITS_W'(cfg_hsize) + BITS_W'(1);

    // one rounded-up word count per pixel depth
    for (genvar c = 0; c < BPP_CODES; c++) begin : g_depth
        localparam int SHIFT = 3 + c;
        logic [BITS_W-1:0] bits_per_line;
        assign bits_per_line = pix_groups << SHIFT;
        assign wpl_cand[c] = WPL_W'((bits_per_line + BITS_W'(15)) >> 4);
    end

    assign wpl_new = wpl_cand[cfg_bpp_code];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q     <= '0;
            s2_q     <= '0;
            split_q  <= '0;
            last_q   <= '0;
            wpl_q    <= WPL_W'(1);
            stride_q <= '0;
        end else if (frame_start) begin
            s1_q     <= cfg_s1_base;
            s2_q     <= cfg_s2_base;
            split_q  <= cfg_split;
            last_q   <= cfg_last_line;
            wpl_q    <= wpl_new;
            stride_q <= ADDR_W'(wpl_new) + ADDR_W'(cfg_pitch);
        end
    end

    // R2
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(s1_q) && $stable(s2_q) && $stable(stride_q)
                          && $stable(split_q) && $stable(last_q)));

endmodule

// File: rtl/split_scan_fsm.sv
module split_scan_fsm
    import split_addr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_start,
    input  logic        line_start,
    input  logic        word_req,
    input  logic        on_last_line,
    input  logic        on_last_word,
    output scan_state_t state,
    output logic        ld_first,
    output logic        ld_next,
    output logic        step
);

    scan_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (frame_start) begin
            state_nx = ST_ARMED;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_ARMED: if (line_start) state_nx = ST_FETCH;
                ST_FETCH: begin
                    if (line_start)
                        state_nx = on_last_line ? ST_DONE : ST_FETCH;
                    else if (word_req && on_last_word)
                        state_nx = ST_HOLD;
                end
                ST_HOLD: if (line_start)
                        state_nx = on_last_line ? ST_DONE : ST_FETCH;
                ST_DONE:  state_nx = ST_DONE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ld_first = 1'b0;
        ld_next  = 1'b0;
        step     = 1'b0;
        if (!frame_start) begin
            unique case (state)
                ST_ARMED: ld_first = line_start;
                ST_FETCH: begin
                    ld_next = line_start && !on_last_line;
                    step    = word_req && !line_start;
                end
                ST_HOLD:  ld_next = line_start && !on_last_line;
                default: ;
            endcase
        end
    end

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !frame_start) |=> state == ST_DONE);

    // R2
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> state == ST_ARMED);

    // R11
    idle_stuck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !frame_start) |=> state == ST_IDLE);

endmodule

// File: rtl/split_scan_addr_gen.sv
module split_scan_addr_gen
    import split_addr_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int LINE_W  = 10,
    parameter int HREG_W  = 8,
    parameter int PITCH_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               line_start,
    input  logic               word_req,
    input  logic [ADDR_W-1:0]  cfg_s1_base,
    input  logic [ADDR_W-1:0]  cfg_s2_base,
    input  logic [LINE_W-1:0]  cfg_split,
    input  logic [LINE_W-1:0]  cfg_last_line,
    input  logic [HREG_W-1:0]  cfg_hsize,
    input  logic [1:0]         cfg_bpp_code,
    input  logic [PITCH_W-1:0] cfg_pitch,
    output logic [ADDR_W-1:0]  fetch_addr,
    output logic               fetch_valid,
    output logic               screen2,
    output logic [LINE_W-1:0]  line_num,
    output logic               frame_done
);

    localparam int WPL_W = HREG_W + 3;

    logic [ADDR_W-1:0] s1_q, s2_q, stride_q;
    logic [LINE_W-1:0] split_q, last_q;
    logic [WPL_W-1:0]  wpl_q;
    logic [WPL_W-1:0]  word_cnt;
    logic [ADDR_W-1:0] line_base;
    logic [ADDR_W-1:0] next_base;
    logic              at_split;
    logic              on_last_line, on_last_word;
    logic              ld_first, ld_next, step;
    scan_state_t       state;

    split_cfg_shadow #(
        .ADDR_W(ADDR_W), .LINE_W(LINE_W), .HREG_W(HREG_W), .PITCH_W(PITCH_W)
    ) u_shadow (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_s1_base(cfg_s1_base), .cfg_s2_base(cfg_s2_base),
        .cfg_split(cfg_split), .cfg_last_line(cfg_last_line),
        .cfg_hsize(cfg_hsize), .cfg_bpp_code(cfg_bpp_code), .cfg_pitch(cfg_pitch),
        .s1_q(s1_q), .s2_q(s2_q), .split_q(split_q), .last_q(last_q),
        .wpl_q(wpl_q), .stride_q(stride_q)
    );

    assign on_last_line = (line_num == last_q);
    assign on_last_word = (word_cnt + WPL_W'(1) == wpl_q);
    assign at_split     = (line_num == split_q);
    assign next_base    = at_split ? s2_q : line_base + stride_q;

    split_scan_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .frame_start(frame_start), .line_start(line_start), .word_req(word_req),
        .on_last_line(on_last_line), .on_last_word(on_last_word),
        .state(state), .ld_first(ld_first), .ld_next(ld_next), .step(step)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_num   <= '0;
            line_base  <= '0;
            fetch_addr <= '0;
            word_cnt   <= '0;
            screen2    <= 1'b0;
        end else if (frame_start) begin
            line_num <= '0;
            word_cnt <= '0;
            screen2  <= 1'b0;
        end else if (ld_first) begin
            line_num   <= '0;
            line_base  <= s1_q;
            fetch_addr <= s1_q;
            word_cnt   <= '0;
            screen2    <= 1'b0;
        end else if (ld_next) begin
            line_num   <= line_num + LINE_W'(1);
            line_base  <= next_base;
            fetch_addr <= next_base;
            word_cnt   <= '0;
            if (at_split) screen2 <= 1'b1;
        end else if (step) begin
            fetch_addr <= fetch_addr + ADDR_W'(1);
            word_cnt   <= word_cnt + WPL_W'(1);
        end
    end

    assign fetch_valid = (state == ST_FETCH);
    assign frame_done  = (state == ST_DONE);

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH && word_req && !line_start && !frame_start)
        |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1));

    // R3
    first_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && line_start && !frame_start)
        |=> (fetch_addr == s1_q && line_num == '0 && !screen2));

    // R7
    screen2_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        screen2 |-> line_num > split_q);

    // R5
    word_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> word_cnt < wpl_q);

endmodule

// File: tb/split_scan_addr_gen_tb.sv
module split_scan_addr_gen_tb;

    localparam int ADDR_W = 16;
    localparam int LINE_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 0, line_start = 0, word_req = 0;
    logic [ADDR_W-1:0] cfg_s1_base = '0, cfg_s2_base = '0;
    logic [LINE_W-1:0] cfg_split = '0, cfg_last_line = '0;
    logic [7:0] cfg_hsize = '0;
    logic [1:0] cfg_bpp_code = '0;
    logic [7:0] cfg_pitch = '0;
    logic [ADDR_W-1:0] fetch_addr;
    logic fetch_valid, screen2, frame_done;
    logic [LINE_W-1:0] line_num;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    split_scan_addr_gen #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
        .word_req(word_req), .cfg_s1_base(cfg_s1_base), .cfg_s2_base(cfg_s2_base),
        .cfg_split(cfg_split), .cfg_last_line(cfg_last_line), .cfg_hsize(cfg_hsize),
        .cfg_bpp_code(cfg_bpp_code), .cfg_pitch(cfg_pitch), .fetch_addr(fetch_addr),
        .fetch_valid(fetch_valid), .screen2(screen2), .line_num(line_num),
        .frame_done(frame_done)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int words_of(input int h, input int code);
        return (8 * (h + 1) * (1 << code) + 15) / 16;
    endfunction

    task automatic drive(input logic fs, input logic ls, input logic wr);
        @(negedge clk);
        frame_start = fs; line_start = ls; word_req = wr;
        @(negedge clk);
        frame_start = 0; line_start = 0; word_req = 0;
    endtask

    task automatic setcfg(input int s1, input int s2, input int sp, input int last,
                          input int h, input int code, input int pitch);
        cfg_s1_base = ADDR_W'(s1); cfg_s2_base = ADDR_W'(s2);
        cfg_split = LINE_W'(sp); cfg_last_line = LINE_W'(last);
        cfg_hsize = 8'(h); cfg_bpp_code = 2'(code); cfg_pitch = 8'(pitch);
    endtask

    task automatic t_reset();
        check("R1 valid", fetch_valid, 0);
        check("R1 done", frame_done, 0);
        check("R1 addr", fetch_addr, 0);
        check("R1 line", line_num, 0);
        check("R1 screen2", screen2, 0);
        setcfg(16'h0300, 0, 5, 5, 3, 0, 0);
        drive(0, 1, 1);
        check("R11 idle line_start ignored", fetch_valid, 0);
        check("R11 idle addr", fetch_addr, 0);
    endtask

    task automatic t_depths();
        for (int code = 0; code < 4; code++) begin
            int w = words_of(3, code);
            setcfg(16'h0400 + code * 16'h100, 0, 9, 9, 3, code, 0);
            drive(1, 0, 0);
            drive(0, 0, 1);
            check("R11 armed word_req ignored", fetch_valid, 0);
            drive(0, 1, 0);
            check("R3 line0 base", fetch_addr, 16'h0400 + code * 16'h100);
            check("R3 valid", fetch_valid, 1);
            for (int k = 0; k < w - 1; k++) drive(0, 0, 1);
            check("R4 still fetching", fetch_valid, 1);
            drive(0, 0, 1);
            check("R4 line filled", fetch_valid, 0);
            check("R5 addr after words", fetch_addr, 16'h0400 + code * 16'h100 + w);
            drive(0, 0, 1);
            check("R5 extra req ignored", fetch_addr, 16'h0400 + code * 16'h100 + w);
        end
        setcfg(16'h0010, 0, 9, 9, 0, 0, 0);
        drive(1, 0, 0);
        drive(0, 1, 0);
        drive(0, 0, 1);
        check("R4 rounded up single word", fetch_valid, 0);
        check("R4 rounded addr", fetch_addr, 16'h0011);
    endtask

    task automatic t_stride();
        int st = words_of(9, 2) + 5;
        setcfg(16'h1000, 16'h9000, 20, 20, 9, 2, 5);
        drive(1, 0, 0);
        drive(0, 1, 0);
        drive(0, 0, 1);
        drive(0, 0, 1);
        drive(0, 1, 0);
        check("R6 line1 base", fetch_addr, 16'h1000 + st);
        check("R10 abandon line", fetch_valid, 1);
        drive(0, 1, 1);
        check("R10 line_start beats word_req", fetch_addr, 16'h1000 + 2 * st);
        check("R6 line index", line_num, 2);
    endtask

    task automatic t_split();
        int n1 = 0, n2 = 0, w = words_of(39, 0);
        bit bad = 0;
        setcfg(16'h0100, 16'h8000, 8'hCE, 239, 39, 0, 0);
        drive(1, 0, 0);
        for (int i = 0; i < 240; i++) begin
            int exp_addr, exp_s2;
            drive(0, 1, 0);
            exp_s2 = (i > 8'hCE);
            exp_addr = exp_s2 ? 16'h8000 + (i - 8'hCF) * w : 16'h0100 + i * w;
            if (screen2) n2++; else n1++;
            if (fetch_addr != ADDR_W'(exp_addr) || screen2 != exp_s2) begin
                if (!bad) check("R7 line base/side", fetch_addr, exp_addr);
                bad = 1;
            end
        end
        check("R7 split bases all match", bad, 0);
        check("R7 screen1 lines", n1, 207);
        check("R7 screen2 lines", n2, 33);
        drive(0, 1, 0);
        check("R8 frame done", frame_done, 1);
        check("R8 valid low", fetch_valid, 0);
        begin
            int held = fetch_addr;
            drive(0, 1, 1);
            check("R8 ignored after end addr", fetch_addr, held);
            check("R8 still done", frame_done, 1);
        end
    endtask

    task automatic t_nosplit();
        for (int sp = 15; sp <= 16 + 200; sp += 201) begin
            int seen = 0;
            setcfg(16'h2000, 16'h7000, sp, 15, 1, 1, 0);
            drive(1, 0, 0);
            for (int i = 0; i < 16; i++) begin
                drive(0, 1, 0);
                if (screen2) seen++;
            end
            check("R9 no screen2 lines", seen, 0);
        end
    endtask

    task automatic t_shadow();
        int wa = words_of(1, 3) + 2;
        setcfg(16'h3000, 16'h5000, 10, 10, 1, 3, 2);
        drive(1, 0, 0);
        setcfg(16'h4000, 16'h6000, 0, 10, 7, 0, 9);
        drive(0, 1, 0);
        check("R2 old s1 kept", fetch_addr, 16'h3000);
        drive(0, 1, 0);
        check("R2 old stride kept", fetch_addr, 16'h3000 + wa);
        check("R2 old split kept", screen2, 0);
        drive(1, 1, 0);
        check("R2 restart armed", fetch_valid, 0);
        check("R2 restart line", line_num, 0);
        drive(0, 1, 0);
        check("R2 new s1", fetch_addr, 16'h4000);
        drive(0, 1, 0);
        check("R2 new split", fetch_addr, 16'h6000);
    endtask

    task automatic t_wrap();
        setcfg(16'hFFF0, 0, 9, 9, 3, 3, 0);
        drive(1, 0, 0);
        drive(0, 1, 0);
        for (int k = 0; k < 15; k++) drive(0, 0, 1);
        check("R5 before wrap", fetch_addr, 16'hFFFF);
        drive(0, 0, 1);
        check("R5 addr wraps", fetch_addr, 16'h0000);
        drive(0, 1, 0);
        check("R6 base wraps", fetch_addr, 16'h0000);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_depths();
                t_stride();
                t_split();
                t_nosplit();
                t_shadow();
                t_wrap();
            end
            begin
                repeat (50000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule